// File: doc/BRIEF.md
# Bus Wait-State Generator

This block decides how long each memory access cycle of a processor bus lasts. When the sequencer strobes the start of a cycle, the block reads a two-bit wait-state field from the status word, a flag that marks the access as internal ROM, and a configuration input that tells whether the core runs at full clock rate. It then asserts a hold signal that stalls the sequencer for the chosen number of wait states. For an external access the hold continues while the slow device keeps its ready line low. When the cycle may end, the block gives a single-clock completion pulse.

Internal ROM does not look at the ready line. At full clock rate it always gets at least one wait state. At reduced clock rate it may run with no wait state at all. The ready line is asynchronous to the core clock, so it passes through a two-flop synchronizer. The block samples the synchronized value only once the programmed wait count has run out.

Top module: `bus_wait_gen`

## Requirements
- R1: For an external access with ready high, the wait field value v (binary 00..11) gives exactly v clock cycles of hold after the start edge. The completion pulse follows in the next cycle. With v = 0 the pulse comes in the cycle right after the start edge, with no hold.
- R2: The completion pulse lasts exactly one clock. In the cycle after it, both hold and the pulse are low, and hold is never high together with the pulse.
- R3: For an external access, a low ready line keeps hold asserted after the wait count has expired. After ready rises, the completion pulse appears in the cycle after the third rising clock edge, because of the two synchronizer stages and the state register.
- R4: An internal ROM access at full clock rate (full-speed input = 1) gets one wait state when the field is 00. With any other field value it gets the field value.
- R5: An internal ROM access at reduced clock rate (full-speed input = 0) gets exactly the field value in wait states, including zero.
- R6: Internal ROM accesses ignore the ready line. A low ready line does not lengthen them.
- R7: A start strobe that arrives while a cycle is active has no effect. The wait field, the internal flag and the full-speed input are taken only at an accepted start, so changes to them during a cycle do not alter it.
- R8: While reset is asserted and right after it is released, hold and the completion pulse are low.
- R9: Hold rises only in the cycle right after an accepted start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_sel | input | 2 | Wait-state field from the status word |
| start | input | 1 | Bus-cycle start strobe, accepted only when idle |
| int_rom | input | 1 | 1 = access targets internal ROM |
| full_speed | input | 1 | 1 = core at full clock rate (internal ROM needs one wait) |
| rdy_async | input | 1 | Asynchronous ready from the external device, high = ready |
| hold | output | 1 | Stretch the current bus cycle |
| done | output | 1 | One-clock pulse at the end of the cycle |

## Verification
On every cycle, the assertions check the following:
- The completion pulse lasts one clock and never overlaps hold.
- Hold only begins right after a start strobe and only ends with the pulse.
- An external cycle finishes only after the synchronized ready was seen high.
- A full-speed internal access always held at least once.

Only the bench scenarios can show the rest:
- the exact wait count for each field value and access type;
- the three-edge latency from a rising ready line to completion;
- that strobes and field changes during a cycle leave its length unchanged.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_READY = 2'd2,
    ST_FIN   = 2'd3
  } bwg_state_e;

endpackage

// File: rtl/bwg_sync.sv
module bwg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bwg_wait_sel.sv
module bwg_wait_sel #(
  parameter int SEL_W    = 2,
  parameter int FAST_MIN = 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             int_rom,
  input  logic             full_speed,
  output logic [SEL_W-1:0] waits
);

  localparam logic [SEL_W-1:0] FAST_MIN_V = SEL_W'(FAST_MIN);

  logic [SEL_W-1:0] floor_v;

  always_comb begin
    floor_v = '0;
    if (int_rom && full_speed) floor_v = FAST_MIN_V;
    waits = (sel < floor_v) ? floor_v : sel;
  end

endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
  import bwg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] waits,
  input  logic             int_rom,
  input  logic             full_speed,
  input  logic             rdy_ok,
  output logic             hold,
  output logic             done,
  output logic             cyc_int,
  output logic             cyc_fast
);

  localparam logic [SEL_W-1:0] ONE = SEL_W'(1);

  bwg_state_e       state_q, state_d;
  logic [SEL_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             int_q, int_d, fast_q, fast_d;
  logic             flag_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    int_d   = int_q;
    fast_d  = fast_q;
    flag_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          flag_en = 1'b1;
          int_d   = int_rom;
          fast_d  = full_speed;
          if (waits != '0) begin
            cnt_en  = 1'b1;
            cnt_d   = waits - ONE;
            state_d = ST_COUNT;
          end else if (int_rom || rdy_ok) begin
            state_d = ST_FIN;
          end else begin
            state_d = ST_READY;
          end
        end
      end
      ST_COUNT: begin
        if (cnt_q != '0) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - ONE;
        end else if (int_q || rdy_ok) begin
          state_d = ST_FIN;
        end else begin
          state_d = ST_READY;
        end
      end
      ST_READY: begin
        if (rdy_ok) state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (flag_en) begin
      int_q  <= int_d;
      fast_q <= fast_d;
    end
  end

  assign hold     = (state_q == ST_COUNT) || (state_q == ST_READY);
  assign done     = (state_q == ST_FIN);
  assign cyc_int  = int_q;
  assign cyc_fast = fast_q;

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_MIN    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ws_sel,
  input  logic             start,
  input  logic             int_rom,
  input  logic             full_speed,
  input  logic             rdy_async,
  output logic             hold,
  output logic             done
);

  logic [SEL_W-1:0] waits;
  logic             rdy_ok;
  logic             cyc_int;
  logic             cyc_fast;

  bwg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rdy_async),
    .q_sync  (rdy_ok)
  );

  bwg_wait_sel #(.SEL_W(SEL_W), .FAST_MIN(FAST_MIN)) u_sel (
    .sel        (ws_sel),
    .int_rom    (int_rom),
    .full_speed (full_speed),
    .waits      (waits)
  );

  bwg_seq #(.SEL_W(SEL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .waits      (waits),
    .int_rom    (int_rom),
    .full_speed (full_speed),
    .rdy_ok     (rdy_ok),
    .hold       (hold),
    .done       (done),
    .cyc_int    (cyc_int),
    .cyc_fast   (cyc_fast)
  );

endmodule

// File: rtl/bwg_chk.sv
module bwg_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic hold,
  input logic done,
  input logic rdy_ok,
  input logic cyc_int,
  input logic cyc_fast
);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold && done));

  a_r1_hold_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> done);

  a_r9_hold_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(start));

  a_r3_rdy_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cyc_int) |-> $past(rdy_ok));

  a_r4_fast_min: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cyc_int && cyc_fast) |-> $past(hold));

endmodule

bind bus_wait_gen bwg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .hold     (hold),
  .done     (done),
  .rdy_ok   (rdy_ok),
  .cyc_int  (cyc_int),
  .cyc_fast (cyc_fast)
);

// File: tb/sim_bus_wait_gen.sv
module sim_bus_wait_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ws_sel;
  logic       start;
  logic       int_rom;
  logic       full_speed;
  logic       rdy_async;
  logic       hold;
  logic       done;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bus_wait_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ws_sel     (ws_sel),
    .start      (start),
    .int_rom    (int_rom),
    .full_speed (full_speed),
    .rdy_async  (rdy_async),
    .hold       (hold),
    .done       (done)
  );

  function automatic int exp_waits(input int sel, input bit irom, input bit fast);
    if (irom && fast && sel < 1) return 1;
    return sel;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one cycle; optional mid-cycle disturbance on the first hold sample.
  task automatic run_cycle(input int sel, input bit irom, input bit fast,
                           input bit disturb, output int holds, output bit got);
    @(negedge clk);
    ws_sel = sel[1:0]; int_rom = irom; full_speed = fast; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    holds = 0; got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (done) begin got = 1'b1; break; end
      if (hold) holds++;
      if (disturb && k == 0) begin
        start = 1'b1; ws_sel = 2'd0; int_rom = ~irom; full_speed = ~fast;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic cycle_and_check(input int sel, input bit irom, input bit fast,
                                 input bit disturb, input string req);
    int  holds;
    bit  got;
    int  e;
    e = exp_waits(sel, irom, fast);
    run_cycle(sel, irom, fast, disturb, holds, got);
    check(got && holds == e, req, holds, e);
    @(negedge clk);
    check(!done && !hold, "R2 idle after pulse", {30'd0, done, hold}, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h1a2b;
    void'($urandom(seed));
    rst_n = 1'b0; ws_sel = 2'd0; start = 1'b0; int_rom = 1'b0;
    full_speed = 1'b1; rdy_async = 1'b1;
    repeat (3) @(negedge clk);
    check(!hold && !done, "R8 in reset", {30'd0, hold, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hold && !done, "R8 after release", {30'd0, hold, done}, 0);
    repeat (3) @(negedge clk);

    // R1: each field value, external, ready high
    for (int s = 0; s < 4; s++) cycle_and_check(s, 1'b0, 1'b1, 1'b0, "R1 external waits");
    // R4 / R5: internal ROM at both clock rates
    for (int s = 0; s < 4; s++) cycle_and_check(s, 1'b1, 1'b1, 1'b0, "R4 internal full speed");
    for (int s = 0; s < 4; s++) cycle_and_check(s, 1'b1, 1'b0, 1'b0, "R5 internal reduced rate");
    // R7: strobe and field changes during an active cycle
    cycle_and_check(3, 1'b0, 1'b1, 1'b1, "R7 mid-cycle start ignored");
    cycle_and_check(2, 1'b1, 1'b0, 1'b1, "R7 mid-cycle fields ignored");

    // R6: internal access with ready low
    rdy_async = 1'b0;
    repeat (4) @(negedge clk);
    cycle_and_check(0, 1'b1, 1'b0, 1'b0, "R6 internal ignores ready");
    cycle_and_check(2, 1'b1, 1'b1, 1'b0, "R6 internal ignores ready");

    // R3: external stall, then release ready
    begin
      int  holds;
      bit  got;
      bit  held_ok;
      int  when;
      @(negedge clk);
      ws_sel = 2'd1; int_rom = 1'b0; full_speed = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      held_ok = 1'b1;
      for (int k = 0; k < 8; k++) begin
        if (!hold || done) held_ok = 1'b0;
        @(negedge clk);
      end
      check(held_ok, "R3 hold while ready low", {31'd0, held_ok}, 1);
      rdy_async = 1'b1;
      when = 0;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (done) begin when = k; break; end
      end
      check(when == 3, "R3 latency after ready rises", when, 3);
      holds = 0; got = 1'b0;
    end
    repeat (3) @(negedge clk);

    // Random mix, ready high
    for (int i = 0; i < 60; i++) begin
      int  s;
      bit  ir, fs;
      s  = $urandom_range(0, 3);
      ir = 1'($urandom_range(0, 1));
      fs = 1'($urandom_range(0, 1));
      cycle_and_check(s, ir, fs, 1'b0, "R1 R4 R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule